// File: doc/BRIEF.md
# SMBus Block Transfer Sequencer with Per-Byte Handshake

This block extends an SMBus host controller so that it can run block reads and block writes. The payload passes one byte at a time through a single block-data register. Software sets the target address, the command byte and, for writes, the byte count and the first payload byte. It then writes the block control code together with the start bit. The sequencer drives a byte-level bus engine through a request/acknowledge interface: start, repeated start, byte write, byte read with ACK or NAK, and stop.

After every payload byte the sequencer raises a sticky byte-done status flag and holds the bus engine. While the flag is set, software reads the received byte or loads the next byte to send. Software then clears the flag with a write-one, which releases the next byte. For a read, the first byte received is the count. It is limited to the range 1 to 32 and written back into data register 0.

An engine-reported collision or missing acknowledge ends the whole block and latches an error flag; the block is never resumed part-way through. A completed block ends with a stop and sets the completion flag in the same cycle that busy falls.

Top module: `smb_blk_xfer`

## Requirements
- R1: After reset the status, data register 0 and block-data register all read 0 and no engine request is raised.
- R2: A control write (select 1) with start bit 6 set begins a block only when the code field bits 4:2 equal 3'b101 (0x14 or 0x34) and status bits 7, 4, 3, 2, 1 and 0 are all clear. With any of those bits set, the start is ignored. With a non-block code and a clear status, the start sets the failed bit 4 and leaves the bus untouched. No engine request is raised while busy (status bit 0) is clear.
- R3: A write block issues START, WRITE of {addr[7:1],0}, WRITE of the command byte, WRITE of the limited count, one WRITE per payload byte taken from the block-data register, then STOP. Engine op codes are START=0, RSTART=1, WRITE=2, READ=3, STOP=4.
- R4: A read block issues START, WRITE {addr[7:1],0}, WRITE command, RSTART, WRITE {addr[7:1],1}, READ of the count, one READ per payload byte, then STOP. Each received payload byte appears in the block-data register (select 5) when byte-done rises.
- R5: A count of 0 is taken as 1 and a count above 32 is taken as 32, both for the write count in data register 0 and for the received read count. On a read the limited count is written into data register 0 (select 4).
- R6: After each payload byte, status bit 7 (byte done) is set, busy stays 1 and the engine request stays low until software clears bit 7. There is exactly one byte-done per payload byte.
- R7: A status write (select 0) clears each of bits 7, 4, 3, 2 and 1 where the written bit is 1. Busy (bit 0) cannot be cleared this way.
- R8: A payload READ is requested with NAK when the control code has bit 5 set (0x34) or when it is the final byte by count. Otherwise it is requested with ACK. The count READ is always acknowledged.
- R9: A missing acknowledge reported by the engine sets status bit 2, issues STOP and ends the block. A collision sets bit 3 and ends the block with no further request. Neither sets the completion bit 1.
- R10: After the final byte-done is cleared the sequencer issues STOP; completion bit 1 is then set in the same cycle that busy falls.
- R11: An engine request keeps its op code and write data stable until the engine acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 status, 1 control, 2 command, 3 address, 4 data 0, 5 block data |
| reg_wdata | input | 8 | Register write data |
| stat_o | output | 8 | Status: bit7 byte done, bit4 failed, bit3 collision, bit2 device error, bit1 complete, bit0 busy |
| data0_o | output | 8 | Data register 0 (byte count) |
| blk_o | output | 8 | Block-data register |
| eng_req | output | 1 | Request to the byte engine, held until acknowledged |
| eng_op | output | 3 | Requested bus operation |
| eng_wdata | output | 8 | Byte to send for WRITE |
| eng_nak | output | 1 | NAK the byte for READ |
| eng_ack | input | 1 | Engine completed the request (one-cycle pulse) |
| eng_rdata | input | 8 | Byte received by READ, valid with eng_ack |
| eng_noack | input | 1 | Target did not acknowledge, valid with eng_ack |
| eng_coll | input | 1 | Bus collision, valid with eng_ack |

## Verification
The assertions check the cycle-level rules on every cycle: the engine is silent while byte-done is set or busy is clear, byte-done never appears without busy, a pending request keeps its op and data, completion coincides with busy falling, and a latched error is never followed by completion. Other behaviour depends on a complete transfer and a model of the engine, so only the bench scenarios show it. This covers the exact order of bus operations, the count limits, the ACK/NAK choice for each read byte, the data placed in the block register, and what happens after an injected missing acknowledge or collision.

// File: rtl/smbblk_pkg.sv
package smbblk_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } eng_op_e;

  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_CTRL = 3'd1;
  localparam logic [2:0] SEL_CMD  = 3'd2;
  localparam logic [2:0] SEL_ADDR = 3'd3;
  localparam logic [2:0] SEL_D0   = 3'd4;
  localparam logic [2:0] SEL_BLK  = 3'd5;

  localparam logic [2:0] CODE_BLOCK = 3'b101;

  typedef struct packed {
    logic              set_bd;
    logic              set_intr;
    logic              set_dev;
    logic              set_coll;
    logic              busy;
    logic              cnt_we;
    logic [BYTE_W-1:0] cnt_val;
    logic              rx_we;
    logic [BYTE_W-1:0] rx_val;
  } seq_evt_t;
endpackage

// File: rtl/smbblk_clamp.sv
module smbblk_clamp
  import smbblk_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6
) (
  input  logic [BYTE_W-1:0] raw,
  output logic [LEN_W-1:0]  len
);
  always_comb begin
    if (raw == '0)
      len = LEN_W'(1);
    else if (int'(raw) > MAX_LEN)
      len = LEN_W'(MAX_LEN);
    else
      len = LEN_W'(raw);
  end
endmodule

// File: rtl/smbblk_regs.sv
module smbblk_regs
  import smbblk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  seq_evt_t          evt,
  output logic [BYTE_W-1:0] stat,
  output logic [BYTE_W-1:0] d0,
  output logic [BYTE_W-1:0] blk,
  output logic [BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0] cmd,
  output logic              code_last,
  output logic              go
);
  logic [3:0]        code_q, code_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d, addr_q, addr_d, d0_q, d0_d, blk_q, blk_d;
  logic              bd_q, bd_d, fail_q, fail_d, coll_q, coll_d;
  logic              dev_q, dev_d, intr_q, intr_d;
  logic              code_en, cmd_en, addr_en, d0_en, blk_en;
  logic              wr_stat, wr_ctrl, idle_ok, is_block, start_req, fail_set;
  logic [BYTE_W-1:0] clr;

  always_comb begin
    wr_stat   = reg_we && (reg_sel == SEL_STAT);
    wr_ctrl   = reg_we && (reg_sel == SEL_CTRL);
    cmd_en    = reg_we && (reg_sel == SEL_CMD);
    addr_en   = reg_we && (reg_sel == SEL_ADDR);
    code_en   = wr_ctrl;
    code_d    = reg_wdata[5:2];
    cmd_d     = reg_wdata;
    addr_d    = reg_wdata;

    idle_ok   = !(bd_q || fail_q || coll_q || dev_q || intr_q || evt.busy);
    is_block  = (code_d[2:0] == CODE_BLOCK);
    start_req = wr_ctrl && reg_wdata[6] && idle_ok;
    go        = start_req && is_block;
    fail_set  = start_req && !is_block;

    clr       = wr_stat ? reg_wdata : '0;
    bd_d      = evt.set_bd   || (bd_q   && !clr[7]);
    fail_d    = fail_set     || (fail_q && !clr[4]);
    coll_d    = evt.set_coll || (coll_q && !clr[3]);
    dev_d     = evt.set_dev  || (dev_q  && !clr[2]);
    intr_d    = evt.set_intr || (intr_q && !clr[1]);

    d0_en     = evt.cnt_we || (reg_we && (reg_sel == SEL_D0));
    d0_d      = evt.cnt_we ? evt.cnt_val : reg_wdata;
    blk_en    = evt.rx_we || (reg_we && (reg_sel == SEL_BLK));
    blk_d     = evt.rx_we ? evt.rx_val : reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cmd_q  <= '0;
      addr_q <= '0;
      d0_q   <= '0;
      blk_q  <= '0;
      bd_q   <= 1'b0;
      fail_q <= 1'b0;
      coll_q <= 1'b0;
      dev_q  <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      if (code_en) code_q <= code_d;
      if (cmd_en)  cmd_q  <= cmd_d;
      if (addr_en) addr_q <= addr_d;
      if (d0_en)   d0_q   <= d0_d;
      if (blk_en)  blk_q  <= blk_d;
      bd_q   <= bd_d;
      fail_q <= fail_d;
      coll_q <= coll_d;
      dev_q  <= dev_d;
      intr_q <= intr_d;
    end
  end

  assign stat      = {bd_q, 2'b00, fail_q, coll_q, dev_q, intr_q, evt.busy};
  assign d0        = d0_q;
  assign blk       = blk_q;
  assign addr      = addr_q;
  assign cmd       = cmd_q;
  assign code_last = code_q[3];
endmodule

// File: rtl/smbblk_seq.sv
module smbblk_seq
  import smbblk_pkg::*;
#(
  parameter int MAX_LEN = 32,
  parameter int LEN_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [BYTE_W-1:0] d0,
  input  logic [BYTE_W-1:0] blk,
  input  logic              code_last,
  input  logic              bd,
  input  logic              eng_ack,
  input  logic [BYTE_W-1:0] eng_rdata,
  input  logic              eng_noack,
  input  logic              eng_coll,
  output seq_evt_t          evt,
  output logic              eng_req,
  output logic [2:0]        eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_nak
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDRW, S_CMD, S_CNTW, S_RSTART,
    S_ADDRR, S_RCNT, S_DATA, S_HOLD, S_STOP, S_FIN
  } seq_st_e;

  seq_st_e           st_q, st_d;
  logic [LEN_W-1:0]  rem_q, rem_d, clamp_len;
  logic [BYTE_W-1:0] clamp_in;
  logic              rd_q, rd_d, err_q, err_d, ok;
  eng_op_e           op;

  assign clamp_in = (st_q == S_RCNT) ? eng_rdata : d0;

  smbblk_clamp #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_clamp (
    .raw (clamp_in),
    .len (clamp_len)
  );

  always_comb begin
    st_d      = st_q;
    rem_d     = rem_q;
    rd_d      = rd_q;
    err_d     = err_q;
    eng_req   = 1'b0;
    op        = OP_START;
    eng_wdata = '0;
    eng_nak   = 1'b0;
    evt       = '0;
    evt.busy  = (st_q != S_IDLE);
    ok        = eng_ack && !eng_coll && !eng_noack;

    case (st_q)
      S_IDLE: begin
        if (go) begin
          st_d  = S_START;
          err_d = 1'b0;
          rd_d  = addr[0];
          rem_d = clamp_len;
        end
      end
      S_START: begin
        eng_req = 1'b1;
        op      = OP_START;
        if (ok) st_d = S_ADDRW;
      end
      S_ADDRW: begin
        eng_req   = 1'b1;
        op        = OP_WRITE;
        eng_wdata = {addr[BYTE_W-1:1], 1'b0};
        if (ok) st_d = S_CMD;
      end
      S_CMD: begin
        eng_req   = 1'b1;
        op        = OP_WRITE;
        eng_wdata = cmd;
        if (ok) st_d = rd_q ? S_RSTART : S_CNTW;
      end
      S_CNTW: begin
        eng_req   = 1'b1;
        op        = OP_WRITE;
        eng_wdata = BYTE_W'(rem_q);
        if (ok) st_d = S_DATA;
      end
      S_RSTART: begin
        eng_req = 1'b1;
        op      = OP_RSTART;
        if (ok) st_d = S_ADDRR;
      end
      S_ADDRR: begin
        eng_req   = 1'b1;
        op        = OP_WRITE;
        eng_wdata = {addr[BYTE_W-1:1], 1'b1};
        if (ok) st_d = S_RCNT;
      end
      S_RCNT: begin
        eng_req = 1'b1;
        op      = OP_READ;
        if (ok) begin
          rem_d       = clamp_len;
          evt.cnt_we  = 1'b1;
          evt.cnt_val = BYTE_W'(clamp_len);
          st_d        = S_DATA;
        end
      end
      S_DATA: begin
        eng_req = 1'b1;
        if (rd_q) begin
          op      = OP_READ;
          eng_nak = code_last || (rem_q == LEN_W'(1));
        end else begin
          op        = OP_WRITE;
          eng_wdata = blk;
        end
        if (ok) begin
          evt.rx_we  = rd_q;
          evt.rx_val = eng_rdata;
          evt.set_bd = 1'b1;
          rem_d      = rem_q - LEN_W'(1);
          st_d       = S_HOLD;
        end
      end
      S_HOLD: begin
        if (!bd) st_d = (rem_q == '0) ? S_STOP : S_DATA;
      end
      S_STOP: begin
        eng_req = 1'b1;
        op      = OP_STOP;
        if (eng_ack) begin
          evt.set_coll = eng_coll;
          err_d        = err_q || eng_coll;
          st_d         = S_FIN;
        end
      end
      S_FIN: begin
        evt.set_intr = !err_q;
        st_d         = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase

    if (eng_req && eng_ack && (st_q != S_STOP)) begin
      if (eng_coll) begin
        evt.set_coll = 1'b1;
        evt.set_bd   = 1'b0;
        evt.rx_we    = 1'b0;
        evt.cnt_we   = 1'b0;
        err_d        = 1'b1;
        st_d         = S_FIN;
      end else if (eng_noack) begin
        evt.set_dev  = 1'b1;
        evt.set_bd   = 1'b0;
        evt.rx_we    = 1'b0;
        evt.cnt_we   = 1'b0;
        err_d        = 1'b1;
        st_d         = S_STOP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      rem_q <= '0;
      rd_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      rd_q  <= rd_d;
      err_q <= err_d;
    end
  end

  assign eng_op = op;
endmodule

// File: rtl/smb_blk_xfer.sv
module smb_blk_xfer
  import smbblk_pkg::*;
#(
  parameter int MAX_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] stat_o,
  output logic [BYTE_W-1:0] data0_o,
  output logic [BYTE_W-1:0] blk_o,
  output logic              eng_req,
  output logic [2:0]        eng_op,
  output logic [BYTE_W-1:0] eng_wdata,
  output logic              eng_nak,
  input  logic              eng_ack,
  input  logic [BYTE_W-1:0] eng_rdata,
  input  logic              eng_noack,
  input  logic              eng_coll
);
  localparam int LEN_W = $clog2(MAX_LEN + 1);

  seq_evt_t          evt;
  logic [BYTE_W-1:0] addr, cmd;
  logic              code_last, go;

  smbblk_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .evt       (evt),
    .stat      (stat_o),
    .d0        (data0_o),
    .blk       (blk_o),
    .addr      (addr),
    .cmd       (cmd),
    .code_last (code_last),
    .go        (go)
  );

  smbblk_seq #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .addr      (addr),
    .cmd       (cmd),
    .d0        (data0_o),
    .blk       (blk_o),
    .code_last (code_last),
    .bd        (stat_o[7]),
    .eng_ack   (eng_ack),
    .eng_rdata (eng_rdata),
    .eng_noack (eng_noack),
    .eng_coll  (eng_coll),
    .evt       (evt),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .eng_wdata (eng_wdata),
    .eng_nak   (eng_nak)
  );
endmodule

// File: rtl/smbblk_chk.sv
module smbblk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] stat_o,
  input logic       eng_req,
  input logic [2:0] eng_op,
  input logic [7:0] eng_wdata,
  input logic       eng_ack
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata))); // R11

  AST_BD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[7] |-> !eng_req); // R6

  AST_BD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[7] |-> stat_o[0]); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_o[0] |-> !eng_req); // R2

  AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[1]) |-> (!stat_o[0] && $past(stat_o[0]))); // R10

  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_o[2] || stat_o[3]) && !stat_o[1]) |=> !stat_o[1]); // R9
endmodule

bind smb_blk_xfer smbblk_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_o    (stat_o),
  .eng_req   (eng_req),
  .eng_op    (eng_op),
  .eng_wdata (eng_wdata),
  .eng_ack   (eng_ack)
);

// File: tb/smb_blk_xfer_bench.sv
module smb_blk_xfer_bench;
  import smbblk_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_we;
  logic [2:0] reg_sel;
  logic [7:0] reg_wdata;
  logic [7:0] stat_o, data0_o, blk_o, eng_wdata, eng_rdata;
  logic       eng_req, eng_nak, eng_ack, eng_noack, eng_coll;
  logic [2:0] eng_op;

  always #5 clk = ~clk;

  smb_blk_xfer u_smb_blk_xfer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .stat_o(stat_o), .data0_o(data0_o), .blk_o(blk_o),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_nak(eng_nak),
    .eng_ack(eng_ack), .eng_rdata(eng_rdata), .eng_noack(eng_noack),
    .eng_coll(eng_coll)
  );

  int n_chk = 0;
  int n_fail = 0;

  // engine log and stimulus
  int         n_log, rd_idx, err_at, err_kind, dly, wcnt;
  logic [2:0] lop  [64];
  logic [7:0] ldat [64];
  logic       lnak [64];
  logic [7:0] rd_src [64];
  int         eop [64];
  int         edat [64];
  int         enak [64];
  int         ne;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int clampf(input int v);
    if (v == 0) return 1;
    if (v > 32) return 32;
    return v;
  endfunction

  task automatic push(input int op, input int d, input int nk);
    eop[ne] = op; edat[ne] = d; enak[ne] = nk; ne++;
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // byte engine model
  initial begin
    eng_ack = 1'b0; eng_noack = 1'b0; eng_coll = 1'b0; eng_rdata = '0;
    n_log = 0; rd_idx = 0; err_at = -1; err_kind = 0; dly = 0; wcnt = 0;
    forever begin
      @(negedge clk);
      if (eng_ack) begin
        eng_ack = 1'b0; eng_noack = 1'b0; eng_coll = 1'b0;
      end else if (eng_req && rst_n) begin
        if (wcnt < dly) wcnt++;
        else begin
          wcnt = 0;
          dly = $urandom % 3;
          if (n_log < 64) begin
            lop[n_log] = eng_op; ldat[n_log] = eng_wdata; lnak[n_log] = eng_nak;
          end
          eng_rdata = (eng_op == 3'd3) ? rd_src[rd_idx % 64] : 8'h00;
          if (eng_op == 3'd3) rd_idx++;
          if (n_log == err_at) begin
            eng_noack = (err_kind == 1);
            eng_coll  = (err_kind == 2);
          end
          n_log++;
          eng_ack = 1'b1;
        end
      end
    end
  end

  task automatic run_xfer(input bit rd, input logic [6:0] a, input logic [7:0] c,
                          input logic [7:0] cntf, input int last_from,
                          input int e_at, input int e_kind);
    int L, k, t;
    logic [7:0] pay [32];
    L = clampf(int'(cntf));
    for (int i = 0; i < 32; i++) pay[i] = 8'($urandom);
    rd_src[0] = cntf;
    for (int i = 0; i < 32; i++) rd_src[i+1] = pay[i];
    n_log = 0; rd_idx = 0; err_at = e_at; err_kind = e_kind;
    ne = 0;
    push(0, 0, 0); push(2, {a, 1'b0}, 0); push(2, c, 0);
    if (rd) begin
      push(1, 0, 0); push(2, {a, 1'b1}, 0); push(3, 0, 0);
      for (int j = 0; j < L; j++) push(3, 0, ((j >= last_from) || (j == L-1)) ? 1 : 0);
    end else begin
      push(2, L, 0);
      for (int j = 0; j < L; j++) push(2, pay[j], 0);
    end
    push(4, 0, 0);
    if (e_kind != 0) begin
      ne = e_at + 1;
      if (e_kind == 1) push(4, 0, 0);
    end
    reg_write(SEL_ADDR, {a, rd});
    reg_write(SEL_CMD, c);
    if (!rd) begin
      reg_write(SEL_D0, cntf);
      reg_write(SEL_BLK, pay[0]);
    end
    reg_write(SEL_CTRL, (rd && last_from == 0) ? 8'h74 : 8'h54);
    k = 0;
    forever begin
      t = 0;
      do begin @(negedge clk); t++; end
      while (!(stat_o[7] || !stat_o[0]) && t < 4000);
      if (t >= 4000) begin chk(0, "R6 byte-done wait timeout", t, 0); break; end
      if (!stat_o[0]) break;
      chk(stat_o[0] == 1'b1, "R6 busy during byte-done", stat_o[0], 1);
      chk(eng_req == 1'b0, "R6 engine idle during byte-done", eng_req, 0);
      if (rd) begin
        if (k == 0) chk(data0_o == 8'(L), "R5 limited count in data0", data0_o, L);
        chk(blk_o == pay[k], "R4 received byte", blk_o, pay[k]);
      end
      if (k == 0) begin
        reg_write(SEL_STAT, 8'h01);
        chk(stat_o[7] && stat_o[0], "R7 busy write ignored", stat_o, 8'h81);
        chk(eng_req == 1'b0, "R6 stall holds", eng_req, 0);
      end
      if (!rd && k + 1 < L) reg_write(SEL_BLK, pay[k+1]);
      if (rd && k + 1 == last_from) reg_write(SEL_CTRL, 8'h34);
      reg_write(SEL_STAT, 8'h80);
      k++;
    end
    chk(n_log == ne, rd ? "R4 op count" : "R3 op count", n_log, ne);
    for (int i = 0; i < ne && i < n_log; i++) begin
      chk(int'(lop[i]) == eop[i], rd ? "R4 op order" : "R3 op order", lop[i], eop[i]);
      if (eop[i] == 2)
        chk(int'(ldat[i]) == edat[i], rd ? "R4 write byte" : "R3 write byte", ldat[i], edat[i]);
      if (eop[i] == 3)
        chk(int'(lnak[i]) == enak[i], "R8 read ack/nak", lnak[i], enak[i]);
    end
    if (e_kind == 0) begin
      chk(k == L, "R6 one byte-done per byte", k, L);
      chk(stat_o == 8'h02, "R10 completion status", stat_o, 8'h02);
    end else if (e_kind == 1) begin
      chk(stat_o == 8'h04, "R9 device error status", stat_o, 8'h04);
    end else begin
      chk(stat_o == 8'h08, "R9 collision status", stat_o, 8'h08);
    end
  endtask

  task automatic clear_all();
    reg_write(SEL_STAT, 8'hFE);
    chk(stat_o == 8'h00, "R7 write-one clear", stat_o, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int snap, L, lf;
    bit r;
    logic [7:0] cf;
    void'($urandom(32'h5A17));
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat_o == 8'h00, "R1 reset status", stat_o, 0);
    chk(data0_o == 8'h00, "R1 reset data0", data0_o, 0);
    chk(blk_o == 8'h00, "R1 reset block", blk_o, 0);
    chk(eng_req == 1'b0, "R1 reset request", eng_req, 0);

    run_xfer(1'b0, 7'h2A, 8'h11, 8'd3, 99, -1, 0);   clear_all();
    run_xfer(1'b0, 7'h15, 8'h22, 8'd0, 99, -1, 0);   clear_all();   // R5 zero
    run_xfer(1'b0, 7'h33, 8'h33, 8'd40, 99, -1, 0);  clear_all();   // R5 high
    run_xfer(1'b1, 7'h48, 8'h44, 8'd0, 99, -1, 0);   clear_all();   // R5 R8
    run_xfer(1'b1, 7'h09, 8'h55, 8'd45, 99, -1, 0);  clear_all();
    run_xfer(1'b1, 7'h61, 8'h66, 8'd5, 2, -1, 0);    clear_all();   // R8 early last code
    run_xfer(1'b1, 7'h61, 8'h67, 8'd3, 0, -1, 0);    clear_all();   // R8 last code at start

    // R9 missing acknowledge on second data byte
    run_xfer(1'b0, 7'h12, 8'h77, 8'd4, 99, 5, 1);
    // R2 start ignored while an error flag is latched
    snap = n_log;
    reg_write(SEL_CTRL, 8'h54);
    for (int i = 0; i < 4; i++) begin
      chk(eng_req == 1'b0 && stat_o[0] == 1'b0, "R2 start ignored with status set", eng_req, 0);
      @(negedge clk);
    end
    chk(n_log == snap, "R2 no bus activity", n_log, snap);
    clear_all();

    // R9 collision during read payload
    run_xfer(1'b1, 7'h3C, 8'h88, 8'd6, 99, 7, 2);    clear_all();

    // R2 non-block code sets failed
    snap = n_log;
    reg_write(SEL_CTRL, 8'h48);
    chk(stat_o == 8'h10, "R2 failed bit on bad code", stat_o, 8'h10);
    repeat (3) @(negedge clk);
    chk(n_log == snap && eng_req == 1'b0, "R2 bad code no bus", n_log, snap);
    clear_all();

    for (int it = 0; it < 10; it++) begin
      r  = 1'($urandom % 2);
      cf = 8'($urandom % 41);
      L  = clampf(int'(cf));
      lf = r ? int'($urandom % (L + 1)) : 99;
      run_xfer(r, 7'($urandom), 8'($urandom), cf, lf, -1, 0);
      clear_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule